// File: doc/BRIEF.md
# Load/Store Address and Part-Word Unit

This unit sits between instruction issue and the data memory port of a 32-bit pipeline. For each memory instruction it forms the effective address from a base register and an offset source, optionally returns an updated base value for the register file (pre- or post-update addressing), and turns the size field into big-endian byte enables with lane-replicated store data. A load's read data returns from memory one cycle after its request. The unit then selects the byte or halfword lane and zero- or sign-extends the value into a 32-bit result for the destination register.

The unit accepts four instruction forms. Register plus 16-bit immediate and register plus 10-bit immediate use signed offsets. A register-register form takes its combined address from an external ALU result. A direct form carries a 21-bit absolute address. The unit also tracks the destination of the load issued in the previous cycle. It raises a one-cycle stall when the instruction being presented reads that register. Misaligned halfword and word accesses are flagged and the memory access is suppressed.

Top module: `mem_access_unit`

## Requirements
- R1: The mode input selects the addressing. 00 gives address = base with no base update. 01 gives address = base and updates the base with base+offset. 10 gives address = base+offset with no update. 11 gives address = base+offset and updates the base with that same sum. Base update is signalled by `base_wb_en` with the value on `base_wb_val`.
- R2: Form code 00 (register-immediate) sign-extends `in_imm[15:0]` as the offset. Form code 10 (part-word) sign-extends `in_imm[9:0]`. Form code 01 (register-register) uses `in_rr_sum` in place of base+offset.
- R3: Form code 11 (direct) drives the address `{11'b0, in_imm[20:2], 2'b00}`, always performs a word access, and never updates the base, whatever the mode.
- R4: Access size follows these rules. Form 01 decodes `in_size[2:1]`: 00 halfword, 10 byte, 01 or 11 word. If `in_rr_op` is 111 in form 01, the access is a word regardless. Form 10 uses `in_size[2]`: 1 byte, 0 halfword. Forms 00 and 11 are always word. `in_size[0]` = 1 zero-extends loads and 0 sign-extends them.
- R5: Byte enables are big-endian. `mem_be[3]` covers `mem_wdata[31:24]`, which is address offset 0. A byte access enables the single lane `4'b1000 >> addr[1:0]`. A halfword access enables 1100 when addr[1]=0 and 0011 when addr[1]=1. A word access enables 1111.
- R6: Stores replicate the low byte of `in_st_data` into all four lanes for byte access, and the low halfword into both halves for halfword access. Word stores pass the data through unchanged.
- R7: A load accepted in cycle N asserts `ld_valid` with `ld_dst` in cycle N+1. In that cycle `ld_data` holds the selected lane of `mem_rdata`, in the same big-endian lane order as R5, extended per R4.
- R8: A halfword access with addr[0]=1, or a word access with addr[1:0]≠0, asserts `align_err`. It also forces `mem_req`, `mem_we` and `mem_be` to zero, and produces no `ld_valid` in the next cycle.
- R9: When a load was accepted in the previous cycle and the valid instruction now presented has `in_src_a` or `in_src_b` equal to that load's destination, `stall` is 1 for exactly one cycle. During that cycle `mem_req` and `base_wb_en` are 0. In the following cycle, with the same instruction held, `stall` is 0 and the access proceeds.
- R10: During and right after reset, `ld_valid` and `stall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A memory instruction is presented |
| in_form | input | 2 | 00 reg+imm16, 01 reg-reg, 10 part-word reg+imm10, 11 direct |
| in_store | input | 1 | 1 store, 0 load |
| in_mode | input | 2 | Addressing mode (R1) |
| in_size | input | 3 | Size and extension field (R4) |
| in_rr_op | input | 3 | ALU operation code of the register-register form |
| in_base | input | 32 | Base register value |
| in_imm | input | 21 | Immediate / direct address field |
| in_rr_sum | input | 32 | External ALU result for the register-register form |
| in_st_data | input | 32 | Store source register value |
| in_dst | input | 5 | Load destination register index |
| in_src_a | input | 5 | First source register index of the presented instruction |
| in_src_b | input | 5 | Second source register index of the presented instruction |
| mem_rdata | input | 32 | Read data, valid the cycle after a load request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Effective address |
| mem_be | output | 4 | Byte enables, bit 3 = offset 0 |
| mem_wdata | output | 32 | Lane-replicated store data |
| align_err | output | 1 | Misaligned access detected |
| base_wb_en | output | 1 | Base register update strobe |
| base_wb_val | output | 32 | Updated base value |
| ld_valid | output | 1 | Load result valid |
| ld_dst | output | 5 | Load result destination |
| ld_data | output | 32 | Aligned, extended load result |
| stall | output | 1 | Load-use stall |

## Verification
The assertions check these properties on every cycle: a post-update or base-only access addresses the unmodified base, and direct-form addresses are word aligned without any base update. A byte access enables exactly one lane. Extended load results have correctly filled upper bits. A misaligned access never reaches memory. A stall never lasts two cycles, and a load result only follows an accepted read. The directed scenarios are what show the actual values. These are the mode-by-mode address and writeback pairs, the offset widths of each form, the exact lane positions for byte and halfword enables and the replicated store data, the lane chosen from returned read data, and the stall-then-proceed sequence on a register dependency.

// File: rtl/mau_pkg.sv
package mau_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  typedef enum logic [1:0] {
    FORM_RI  = 2'b00,
    FORM_RR  = 2'b01,
    FORM_PW  = 2'b10,
    FORM_DIR = 2'b11
  } form_e;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_HALF = 2'b01,
    SZ_BYTE = 2'b10
  } size_e;

  localparam logic [2:0] OP_SHIFT = 3'b111;
endpackage

// File: rtl/mau_addr_gen.sv
module mau_addr_gen
  import mau_pkg::*;
#(
  parameter int IMM_W = 16,
  parameter int PW_W  = 10,
  parameter int FLD_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       form,
  input  logic [1:0]       mode,
  input  logic [DW-1:0]    base,
  input  logic [DW-1:0]    rr_sum,
  input  logic [FLD_W-1:0] fld,
  output logic [DW-1:0]    ea,
  output logic             wb_req,
  output logic [DW-1:0]    wb_val
);
  localparam int RI_PAD  = DW - IMM_W;
  localparam int PW_PAD  = DW - PW_W;
  localparam int DIR_PAD = DW - FLD_W;

  form_e         f;
  logic [DW-1:0] off;
  logic [DW-1:0] sum;

  assign f = form_e'(form);

  always_comb begin
    off = {{RI_PAD{fld[IMM_W-1]}}, fld[IMM_W-1:0]};
    if (f == FORM_PW) off = {{PW_PAD{fld[PW_W-1]}}, fld[PW_W-1:0]};
    sum = (f == FORM_RR) ? rr_sum : base + off;
    if (f == FORM_DIR) begin
      ea     = {{DIR_PAD{1'b0}}, fld[FLD_W-1:2], 2'b00};
      wb_req = 1'b0;
    end else begin
      ea     = mode[1] ? sum : base;
      wb_req = mode[0];
    end
    wb_val = sum;
  end

  // R1: modes 00 and 01 address the base itself
  assert_base_only_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (f != FORM_DIR && !mode[1]) |-> ea == base);
  // R3: direct form is word aligned and never updates the base
  assert_direct_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (f == FORM_DIR) |-> (ea[1:0] == 2'b00 && !wb_req));
endmodule

// File: rtl/mau_lane_fmt.sv
module mau_lane_fmt
  import mau_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    form,
  input  logic [2:0]    size_fld,
  input  logic [2:0]    rr_op,
  input  logic [1:0]    addr_lo,
  input  logic [DW-1:0] st_data,
  output logic [1:0]    size,
  output logic          zext,
  output logic [NB-1:0] be,
  output logic [DW-1:0] wdata,
  output logic          misalign
);
  form_e f;
  size_e sz;

  assign f = form_e'(form);

  always_comb begin
    sz = SZ_WORD;
    unique case (f)
      FORM_RR: begin
        if (rr_op != OP_SHIFT) begin
          unique case (size_fld[2:1])
            2'b00:   sz = SZ_HALF;
            2'b10:   sz = SZ_BYTE;
            default: sz = SZ_WORD;
          endcase
        end
      end
      FORM_PW: sz = size_fld[2] ? SZ_BYTE : SZ_HALF;
      default: sz = SZ_WORD;
    endcase
  end

  always_comb begin
    unique case (sz)
      SZ_BYTE: begin
        be       = 4'b1000 >> addr_lo;
        wdata    = {NB{st_data[7:0]}};
        misalign = 1'b0;
      end
      SZ_HALF: begin
        be       = addr_lo[1] ? 4'b0011 : 4'b1100;
        wdata    = {2{st_data[15:0]}};
        misalign = addr_lo[0];
      end
      default: begin
        be       = {NB{1'b1}};
        wdata    = st_data;
        misalign = |addr_lo;
      end
    endcase
  end

  assign size = sz;
  assign zext = size_fld[0];

  // R5: a byte access enables exactly one lane
  assert_byte_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sz == SZ_BYTE) |-> $countones(be) == 1);
  // R5: a halfword access enables exactly two lanes
  assert_half_two_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sz == SZ_HALF) |-> $countones(be) == 2);
endmodule

// File: rtl/mau_load_align.sv
module mau_load_align
  import mau_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  logic [DW-1:0] rdata,
  input  logic [1:0]    size,
  input  logic [1:0]    lane,
  input  logic          zext,
  output logic [DW-1:0] data
);
  size_e sz;
  logic [7:0]  b;
  logic [15:0] h;

  assign sz = size_e'(size);

  always_comb begin
    unique case (lane)
      2'd0:    b = rdata[31:24];
      2'd1:    b = rdata[23:16];
      2'd2:    b = rdata[15:8];
      default: b = rdata[7:0];
    endcase
    h = lane[1] ? rdata[15:0] : rdata[31:16];
    unique case (sz)
      SZ_BYTE: data = {{(DW-8){~zext & b[7]}}, b};
      SZ_HALF: data = {{(DW-16){~zext & h[15]}}, h};
      default: data = rdata;
    endcase
  end

  // R7: zero-extended byte loads leave the upper bits clear
  assert_byte_zext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && sz == SZ_BYTE && zext) |-> data[31:8] == 24'h0);
  // R7: sign-extended halfword loads replicate bit 15
  assert_half_sext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && sz == SZ_HALF && !zext) |-> data[31:16] == {16{data[15]}});
endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit
  import mau_pkg::*;
#(
  parameter int IMM_W = 16,
  parameter int PW_W  = 10,
  parameter int FLD_W = 21,
  parameter int RI_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_form,
  input  logic             in_store,
  input  logic [1:0]       in_mode,
  input  logic [2:0]       in_size,
  input  logic [2:0]       in_rr_op,
  input  logic [31:0]      in_base,
  input  logic [FLD_W-1:0] in_imm,
  input  logic [31:0]      in_rr_sum,
  input  logic [31:0]      in_st_data,
  input  logic [RI_W-1:0]  in_dst,
  input  logic [RI_W-1:0]  in_src_a,
  input  logic [RI_W-1:0]  in_src_b,
  input  logic [31:0]      mem_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  output logic             align_err,
  output logic             base_wb_en,
  output logic [31:0]      base_wb_val,
  output logic             ld_valid,
  output logic [RI_W-1:0]  ld_dst,
  output logic [31:0]      ld_data,
  output logic             stall
);
  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s  <= rst_s1;
    end
  end

  logic [DW-1:0] ea;
  logic          wb_req;
  logic [1:0]    size;
  logic          zext;
  logic [NB-1:0] be;
  logic          misalign;
  logic          accept;

  mau_addr_gen #(.IMM_W(IMM_W), .PW_W(PW_W), .FLD_W(FLD_W)) u_addr (
    .clk(clk), .rst_n(rst_s), .form(in_form), .mode(in_mode),
    .base(in_base), .rr_sum(in_rr_sum), .fld(in_imm),
    .ea(ea), .wb_req(wb_req), .wb_val(base_wb_val)
  );

  mau_lane_fmt u_lane (
    .clk(clk), .rst_n(rst_s), .form(in_form), .size_fld(in_size),
    .rr_op(in_rr_op), .addr_lo(ea[1:0]), .st_data(in_st_data),
    .size(size), .zext(zext), .be(be), .wdata(mem_wdata), .misalign(misalign)
  );

  // pending-load state
  logic            pend_q, pend_d;
  logic [RI_W-1:0] pdst_q;
  logic [1:0]      psize_q, plane_q;
  logic            pzext_q;

  always_comb begin
    stall      = in_valid & pend_q & ((in_src_a == pdst_q) | (in_src_b == pdst_q));
    accept     = in_valid & ~stall;
    mem_req    = accept & ~misalign;
    mem_we     = mem_req & in_store;
    mem_be     = mem_req ? be : '0;
    mem_addr   = ea;
    align_err  = accept & misalign;
    base_wb_en = accept & wb_req;
    pend_d     = mem_req & ~in_store;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pdst_q  <= '0;
      psize_q <= '0;
      plane_q <= '0;
      pzext_q <= 1'b0;
    end else if (pend_d) begin
      pdst_q  <= in_dst;
      psize_q <= size;
      plane_q <= ea[1:0];
      pzext_q <= zext;
    end
  end

  mau_load_align u_load (
    .clk(clk), .rst_n(rst_s), .chk_en(pend_q), .rdata(mem_rdata),
    .size(psize_q), .lane(plane_q), .zext(pzext_q), .data(ld_data)
  );

  assign ld_valid = pend_q;
  assign ld_dst   = pdst_q;

  // R9: a load-use stall lasts a single cycle
  assert_stall_single_R9: assert property (@(posedge clk) disable iff (!rst_s)
    stall |=> !stall);
  // R7: a load result only follows an accepted read request
  assert_ld_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_s)
    ld_valid |-> $past(mem_req && !mem_we));
  // R8: a misaligned access never reaches memory
  assert_misalign_blocked_R8: assert property (@(posedge clk) disable iff (!rst_s)
    align_err |-> (!mem_req && !mem_we && mem_be == 4'b0000));
  // R9: no memory request while stalled
  assert_stall_no_req_R9: assert property (@(posedge clk) disable iff (!rst_s)
    stall |-> (!mem_req && !base_wb_en));
endmodule

// File: tb/tb_mem_access_unit.sv
module tb_mem_access_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_store;
  logic [1:0]  in_form, in_mode;
  logic [2:0]  in_size, in_rr_op;
  logic [31:0] in_base, in_rr_sum, in_st_data, mem_rdata;
  logic [20:0] in_imm;
  logic [4:0]  in_dst, in_src_a, in_src_b;
  logic        mem_req, mem_we, align_err, base_wb_en, ld_valid, stall;
  logic [31:0] mem_addr, mem_wdata, base_wb_val, ld_data;
  logic [3:0]  mem_be;
  logic [4:0]  ld_dst;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mem_access_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_form(in_form),
    .in_store(in_store), .in_mode(in_mode), .in_size(in_size),
    .in_rr_op(in_rr_op), .in_base(in_base), .in_imm(in_imm),
    .in_rr_sum(in_rr_sum), .in_st_data(in_st_data), .in_dst(in_dst),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .align_err(align_err), .base_wb_en(base_wb_en),
    .base_wb_val(base_wb_val), .ld_valid(ld_valid), .ld_dst(ld_dst),
    .ld_data(ld_data), .stall(stall)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 0; in_store = 0; in_form = 2'b00; in_mode = 2'b00;
    in_size = 3'b010; in_rr_op = 3'b000; in_base = 0; in_imm = 0;
    in_rr_sum = 0; in_st_data = 0; in_dst = 0; in_src_a = 0; in_src_b = 0;
  endtask

  // drive after a falling edge, sample one time unit later
  task automatic step();
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] form, input logic [1:0] mode,
                       input logic [2:0] size, input logic [2:0] op,
                       input logic st, input logic [31:0] base,
                       input logic [20:0] imm, input logic [31:0] rr);
    step();
    idle();
    in_valid = 1; in_form = form; in_mode = mode; in_size = size;
    in_rr_op = op; in_store = st; in_base = base; in_imm = imm; in_rr_sum = rr;
    in_st_data = 32'hCAFE_BA5E; in_dst = 5'd9; in_src_a = 5'd1; in_src_b = 5'd2;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R10 ld_valid in reset", {31'b0, ld_valid}, 32'h0);
    chk("R10 stall in reset", {31'b0, stall}, 32'h0);
  endtask

  task automatic t_modes();
    issue(2'b00, 2'b00, 3'b010, 3'b000, 1'b1, 32'h1000, 21'h10, 0);
    chk("R1 mode00 addr", mem_addr, 32'h1000);
    chk("R1 mode00 wb", {31'b0, base_wb_en}, 0);
    issue(2'b00, 2'b01, 3'b010, 3'b000, 1'b1, 32'h1000, 21'h10, 0);
    chk("R1 mode01 addr", mem_addr, 32'h1000);
    chk("R1 mode01 wb", {31'b0, base_wb_en}, 1);
    chk("R1 mode01 wbval", base_wb_val, 32'h1010);
    issue(2'b00, 2'b10, 3'b010, 3'b000, 1'b1, 32'h1000, 21'h10, 0);
    chk("R1 mode10 addr", mem_addr, 32'h1010);
    chk("R1 mode10 wb", {31'b0, base_wb_en}, 0);
    issue(2'b00, 2'b11, 3'b010, 3'b000, 1'b1, 32'h1000, 21'h10, 0);
    chk("R1 mode11 addr", mem_addr, 32'h1010);
    chk("R1 mode11 wbval", base_wb_val, 32'h1010);
  endtask

  task automatic t_offsets();
    issue(2'b00, 2'b10, 3'b010, 3'b000, 1'b1, 32'h1000, 21'h0FFFC, 0);
    chk("R2 imm16 negative", mem_addr, 32'h0FFC);
    issue(2'b10, 2'b10, 3'b010, 3'b000, 1'b1, 32'h1000, 21'h003F8, 0);
    chk("R2 imm10 negative", mem_addr, 32'h0FF8);
    issue(2'b01, 2'b10, 3'b010, 3'b000, 1'b1, 32'h1000, 21'h0, 32'h2000);
    chk("R2 reg-reg sum", mem_addr, 32'h2000);
  endtask

  task automatic t_direct();
    issue(2'b11, 2'b11, 3'b100, 3'b000, 1'b1, 32'h1000, 21'h1FFFFF, 0);
    chk("R3 direct addr", mem_addr, 32'h001F_FFFC);
    chk("R3 direct be", {28'b0, mem_be}, 32'hF);
    chk("R3 direct no wb", {31'b0, base_wb_en}, 0);
    chk("R3 direct no err", {31'b0, align_err}, 0);
  endtask

  task automatic t_store_lanes();
    issue(2'b01, 2'b10, 3'b100, 3'b000, 1'b1, 0, 0, 32'h4001);
    chk("R5 byte be", {28'b0, mem_be}, 32'h4);
    chk("R6 byte wdata", mem_wdata, 32'h5E5E_5E5E);
    chk("R5 byte we", {31'b0, mem_we}, 1);
    issue(2'b01, 2'b10, 3'b000, 3'b000, 1'b1, 0, 0, 32'h4002);
    chk("R5 half be", {28'b0, mem_be}, 32'h3);
    chk("R6 half wdata", mem_wdata, 32'hBA5E_BA5E);
    issue(2'b01, 2'b10, 3'b100, 3'b111, 1'b1, 0, 0, 32'h4000);
    chk("R4 shift op forces word", {28'b0, mem_be}, 32'hF);
    chk("R6 word wdata", mem_wdata, 32'hCAFE_BA5E);
    issue(2'b00, 2'b00, 3'b100, 3'b000, 1'b1, 32'h4000, 0, 0);
    chk("R4 reg-imm always word", {28'b0, mem_be}, 32'hF);
    issue(2'b10, 2'b00, 3'b100, 3'b000, 1'b1, 32'h4003, 0, 0);
    chk("R4 part-word byte lane3", {28'b0, mem_be}, 32'h1);
    issue(2'b01, 2'b10, 3'b110, 3'b000, 1'b1, 0, 0, 32'h4000);
    chk("R4 size 11 is word", {28'b0, mem_be}, 32'hF);
  endtask

  task automatic t_loads();
    issue(2'b01, 2'b10, 3'b101, 3'b000, 1'b0, 0, 0, 32'h3001);
    chk("R7 load req", {31'b0, mem_req}, 1);
    step(); idle(); mem_rdata = 32'h11A2_3344; #1;
    chk("R7 ld_valid", {31'b0, ld_valid}, 1);
    chk("R7 ld_dst", {27'b0, ld_dst}, 32'd9);
    chk("R7 byte zext lane1", ld_data, 32'h0000_00A2);
    issue(2'b01, 2'b10, 3'b100, 3'b000, 1'b0, 0, 0, 32'h3001);
    step(); idle(); mem_rdata = 32'h11A2_3344; #1;
    chk("R7 byte sext lane1", ld_data, 32'hFFFF_FFA2);
    issue(2'b01, 2'b10, 3'b000, 3'b000, 1'b0, 0, 0, 32'h3002);
    step(); idle(); mem_rdata = 32'h1234_8001; #1;
    chk("R7 half sext lane2", ld_data, 32'hFFFF_8001);
    issue(2'b00, 2'b00, 3'b010, 3'b000, 1'b0, 32'h3000, 0, 0);
    step(); idle(); mem_rdata = 32'h1234_8001; #1;
    chk("R7 word load", ld_data, 32'h1234_8001);
    step(); #1;
    chk("R7 no ld_valid when idle", {31'b0, ld_valid}, 0);
  endtask

  task automatic t_align();
    issue(2'b01, 2'b10, 3'b000, 3'b000, 1'b0, 0, 0, 32'h4001);
    chk("R8 half odd err", {31'b0, align_err}, 1);
    chk("R8 half odd no req", {31'b0, mem_req}, 0);
    chk("R8 half odd be", {28'b0, mem_be}, 0);
    step(); idle(); #1;
    chk("R8 no load result", {31'b0, ld_valid}, 0);
    issue(2'b01, 2'b10, 3'b010, 3'b000, 1'b1, 0, 0, 32'h4002);
    chk("R8 word err", {31'b0, align_err}, 1);
    chk("R8 word no we", {31'b0, mem_we}, 0);
  endtask

  task automatic t_stall();
    issue(2'b00, 2'b00, 3'b010, 3'b000, 1'b0, 32'h5000, 0, 0);
    in_dst = 5'd5; #1;
    step();
    in_store = 1; in_mode = 2'b01; in_src_a = 5'd5; in_src_b = 5'd7; in_dst = 5'd3; #1;
    chk("R9 stall raised", {31'b0, stall}, 1);
    chk("R9 no req in stall", {31'b0, mem_req}, 0);
    chk("R9 no wb in stall", {31'b0, base_wb_en}, 0);
    step(); #1;
    chk("R9 stall released", {31'b0, stall}, 0);
    chk("R9 access proceeds", {31'b0, mem_we}, 1);
    issue(2'b00, 2'b00, 3'b010, 3'b000, 1'b0, 32'h5000, 0, 0);
    in_dst = 5'd5; #1;
    step(); in_src_a = 5'd6; in_src_b = 5'd7; #1;
    chk("R9 no stall unrelated", {31'b0, stall}, 0);
    step(); idle();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    mem_rdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_modes();
    t_offsets();
    t_direct();
    t_store_lanes();
    t_loads();
    t_align();
    t_stall();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule